// File: doc/BRIEF.md
# Gated Retriggerable One-Shot Timer

This block is a clocked pulse stretcher that takes the place of a resistor-capacitor monostable. Two groups of trigger inputs feed a gate. The first group is active-low, and its term is true when any member is low. The second group is active-high, and its term is true only when every member is high. The gate result is ANDed with an active-low clear. When the combined condition goes from false to true, the output `q_o` goes high for a number of clock cycles taken from a runtime input. `q_n_o` is always its complement.

Every input passes through a two-stage synchroniser. The trigger inputs then pass a stability filter, so a level is used only after it has held for `STABLE` consecutive cycles. The clear skips the filter, so it acts on the first edge after synchronisation. A fresh qualifying trigger reloads the full width, which stretches the pulse. It is taken only after a runtime recovery interval has run out since the last accepted trigger. A trigger inside that interval is dropped and is not queued.

Top module: `retrig_oneshot`

## Requirements
- R1: The active-low term is true when at least one `trig_lo_i` bit is low. A bit falling to low, or two bits falling to low together, can start a pulse. When all `trig_lo_i` bits are high, a rise of `trig_hi_i` starts nothing.
- R2: The active-high term is true only when all `trig_hi_i` bits are high. While any bit is low, a fall of `trig_lo_i` starts nothing.
- R3: A pulse starts when (any `trig_lo_i` low) AND (all `trig_hi_i` high) AND (`clr_n_i` high) goes from false to true. If a trigger input causes the transition and is driven just after clock edge 0, `q_o` is high after edge 3+STABLE. If a rising `clr_n_i` causes it, `q_o` is high after edge 3.
- R4: An accepted trigger samples `width_i`, and `q_o` then stays high for `width_i`+1 cycles. A value of 0 gives one cycle.
- R5: While the synchronised clear is low, `q_o` is held low and trigger activity is ignored.
- R6: If `clr_n_i` is driven low just after edge 0 during a pulse, `q_o` is low after edge 3, before the programmed width has run out.
- R7: An accepted retrigger reloads the full width counted from that trigger. Qualifying triggers spaced no further apart than the width+1 keep `q_o` high without a break.
- R8: An accepted trigger loads `holdoff_i`. A later trigger edge is accepted only if it comes more than `holdoff_i` cycles after the previous accepted one. Otherwise it has no effect on the running pulse.
- R9: A trigger-input level that lasts fewer than `STABLE` cycles is not used. A level that lasts exactly `STABLE` cycles is used.
- R10: `q_n_o` equals the inverse of `q_o` in every cycle.
- R11: During and just after reset, `q_o` is 0 and `q_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_lo_i | input | NUM_A | Active-low trigger inputs, any low qualifies |
| trig_hi_i | input | NUM_B | Active-high trigger inputs, all high qualify |
| clr_n_i | input | 1 | Active-low clear. Its rising edge may also fire |
| width_i | input | CNT_W | Pulse length minus one, in cycles |
| holdoff_i | input | CNT_W | Recovery interval after an accepted trigger |
| q_o | output | 1 | Pulse output |
| q_n_o | output | 1 | Complement of the pulse output |

## Verification
The hardest case to reach is a second trigger edge that arrives while a pulse is running, placed exactly on the boundary of the recovery interval. The trigger input must go inactive and then active again, and each level has to survive the stability filter. The bench toggles an active-low input with its inactive gap set to exactly `STABLE` cycles. It sweeps the spacing between falls against several recovery values, including spacings equal to and one more than the interval. A run of triggers at a fixed spacing then checks that the output never drops.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
   // synchroniser depth used for every asynchronous input
   localparam int SYNC_DEPTH = 2;
   // level a trigger group takes in reset (inactive value)
   typedef enum logic {LVL_LOW = 1'b0, LVL_HIGH = 1'b1} idle_lvl_e;
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync
   import oneshot_pkg::*;
#(
   parameter int        N     = 1,
   parameter idle_lvl_e IDLE  = LVL_LOW
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   localparam logic [N-1:0] RST_V = {N{logic'(IDLE)}};

   logic [N-1:0] stage [SYNC_DEPTH];

   generate
      if (SYNC_DEPTH < 2) begin : g_bad_depth
         $error("synchroniser needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_DEPTH; s++) stage[s] <= RST_V;
      end else begin
         stage[0] <= d;
         for (int s = 1; s < SYNC_DEPTH; s++) stage[s] <= stage[s-1];
      end
   end

   assign q = stage[SYNC_DEPTH-1];
endmodule

// File: rtl/oneshot_filt.sv
module oneshot_filt
   import oneshot_pkg::*;
#(
   parameter int        N      = 1,
   parameter int        STABLE = 2,
   parameter idle_lvl_e IDLE   = LVL_LOW
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   generate
      if (STABLE < 1) begin : g_bad
         $error("STABLE must be at least 1");
      end else if (STABLE == 1) begin : g_pass
         for (genvar i = 0; i < N; i++) begin : g_bit
            logic lvl;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) lvl <= logic'(IDLE);
               else        lvl <= d[i];
            end
            assign q[i] = lvl;
         end
      end else begin : g_count
         localparam int CW = $clog2(STABLE);
         localparam logic [CW-1:0] LAST = CW'(STABLE - 1);
         for (genvar i = 0; i < N; i++) begin : g_bit
            logic          lvl;
            logic [CW-1:0] run;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  lvl <= logic'(IDLE);
                  run <= '0;
               end else if (d[i] == lvl) begin
                  run <= '0;
               end else if (run == LAST) begin
                  lvl <= d[i];
                  run <= '0;
               end else begin
                  run <= run + 1'b1;
               end
            end
            assign q[i] = lvl;
         end
      end
   endgenerate
endmodule

// File: rtl/oneshot_gate.sv
module oneshot_gate #(
   parameter int NUM_A = 2,
   parameter int NUM_B = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_A-1:0] lo_lvl,
   input  logic [NUM_B-1:0] hi_lvl,
   input  logic             clr_ok,
   output logic             fire
);
   logic cond, cond_q;

   assign cond = (~&lo_lvl) & (&hi_lvl) & clr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond;
   end

   assign fire = cond & ~cond_q;
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_ok,
   input  logic             fire,
   input  logic [CNT_W-1:0] width,
   input  logic [CNT_W-1:0] holdoff,
   output logic             active,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] hold
);
   logic take;

   assign take = fire & (hold == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         hold   <= '0;
      end else if (!clr_ok) begin
         active <= 1'b0;
         cnt    <= '0;
         hold   <= '0;
      end else if (take) begin
         active <= 1'b1;
         cnt    <= width;
         hold   <= holdoff;
      end else begin
         if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
         end
         if (hold != '0) hold <= hold - 1'b1;
      end
   end
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
   import oneshot_pkg::*;
#(
   parameter int NUM_A  = 2,
   parameter int NUM_B  = 2,
   parameter int CNT_W  = 16,
   parameter int STABLE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_A-1:0] trig_lo_i,
   input  logic [NUM_B-1:0] trig_hi_i,
   input  logic             clr_n_i,
   input  logic [CNT_W-1:0] width_i,
   input  logic [CNT_W-1:0] holdoff_i,
   output logic             q_o,
   output logic             q_n_o
);
   generate
      if (NUM_A < 1 || NUM_B < 1) begin : g_bad_groups
         $error("each trigger group needs at least one input");
      end
      if (CNT_W < 1) begin : g_bad_width
         $error("CNT_W must be positive");
      end
   endgenerate

   logic [NUM_A-1:0] lo_s, lo_f;
   logic [NUM_B-1:0] hi_s, hi_f;
   logic             clr_s;
   logic             fire;
   logic             active;
   logic [CNT_W-1:0] cnt_w, hold_w;

   oneshot_sync #(.N(NUM_A), .IDLE(LVL_HIGH)) u_sync_lo (
      .clk(clk), .rst_n(rst_n), .d(trig_lo_i), .q(lo_s));
   oneshot_sync #(.N(NUM_B), .IDLE(LVL_LOW)) u_sync_hi (
      .clk(clk), .rst_n(rst_n), .d(trig_hi_i), .q(hi_s));
   oneshot_sync #(.N(1), .IDLE(LVL_LOW)) u_sync_clr (
      .clk(clk), .rst_n(rst_n), .d(clr_n_i), .q(clr_s));

   oneshot_filt #(.N(NUM_A), .STABLE(STABLE), .IDLE(LVL_HIGH)) u_filt_lo (
      .clk(clk), .rst_n(rst_n), .d(lo_s), .q(lo_f));
   oneshot_filt #(.N(NUM_B), .STABLE(STABLE), .IDLE(LVL_LOW)) u_filt_hi (
      .clk(clk), .rst_n(rst_n), .d(hi_s), .q(hi_f));

   oneshot_gate #(.NUM_A(NUM_A), .NUM_B(NUM_B)) u_gate (
      .clk(clk), .rst_n(rst_n), .lo_lvl(lo_f), .hi_lvl(hi_f),
      .clr_ok(clr_s), .fire(fire));

   oneshot_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr_ok(clr_s), .fire(fire),
      .width(width_i), .holdoff(holdoff_i),
      .active(active), .cnt(cnt_w), .hold(hold_w));

   assign q_o   = active;
   assign q_n_o = ~active;
endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             q,
   input logic             clr_s,
   input logic             fire,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] hold,
   input logic [CNT_W-1:0] width
);
   // R5
   clear_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_s |=> !q);

   // R3
   rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q) |-> $past(fire));

   // R4
   accept_loads_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && hold == '0 && clr_s) |=> (q && cnt == $past(width)));

   // R8
   early_retrig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && hold != '0 && clr_s && q && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   // R6
   end_only_by_count_or_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(q) |-> ($past(cnt) == '0 || !$past(clr_s)));
endmodule

bind retrig_oneshot oneshot_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .q(q_o), .clr_s(clr_s), .fire(fire),
   .cnt(cnt_w), .hold(hold_w), .width(width_i));

// File: tb/sim_retrig_oneshot.sv
`timescale 1ns/100ps
module sim_retrig_oneshot;
   localparam int NA  = 2;
   localparam int NB  = 2;
   localparam int CW  = 16;
   localparam int STB = 2;
   localparam int LAT_TRIG = 3 + STB;
   localparam int LAT_CLR  = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NA-1:0] a;
   logic [NB-1:0] b;
   logic          c;
   logic [CW-1:0] w, h;
   logic          q, qn;

   int checks = 0;
   int errors = 0;
   int k, hi_cnt, first_hi, rises;
   logic prev_q;

   always #2.5 clk = ~clk;

   retrig_oneshot #(.NUM_A(NA), .NUM_B(NB), .CNT_W(CW), .STABLE(STB)) u0 (
      .clk(clk), .rst_n(rst_n), .trig_lo_i(a), .trig_hi_i(b), .clr_n_i(c),
      .width_i(w), .holdoff_i(h), .q_o(q), .q_n_o(qn));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic mark();
      k = 0; hi_cnt = 0; first_hi = -1; rises = 0; prev_q = q;
   endtask

   // sample at negedge k (after posedge k); R10 checked every cycle
   task automatic step();
      @(negedge clk);
      k++;
      chk(qn == ~q, "R10 complement", int'(qn), int'(~q));
      if (q) begin
         hi_cnt++;
         if (first_hi < 0) first_hi = k;
         if (!prev_q) rises++;
      end
      prev_q = q;
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic go_idle();
      a = '1; b = '1; c = 1'b1;
      steps(12);
   endtask

   // sources: 0 lo[0] falls, 1 lo[1] falls, 2 hi[0] rises, 3 hi[1] rises, 4 clear rises
   task automatic run_src(input int src, input int wid);
      w = CW'(wid); h = '0;
      go_idle();
      case (src)
         2: begin b = 2'b10; steps(6); a = 2'b10; steps(6); end
         3: begin b = 2'b01; steps(6); a = 2'b10; steps(6); end
         4: begin c = 1'b0; steps(6); a = 2'b10; steps(6); end
         default: ;
      endcase
      mark();
      case (src)
         0: a = 2'b10;
         1: a = 2'b01;
         2, 3: b = 2'b11;
         default: c = 1'b1;
      endcase
      steps(40);
      chk(first_hi == ((src == 4) ? LAT_CLR : LAT_TRIG), "R3 start latency",
          first_hi, (src == 4) ? LAT_CLR : LAT_TRIG);
      chk(hi_cnt == wid + 1, "R4 pulse length", hi_cnt, wid + 1);
      chk(rises == 1, "R4 single pulse", rises, 1);
      go_idle();
   endtask

   // second fall D cycles after the first; inactive gap of exactly STB cycles (R9 boundary)
   task automatic run_retrig(input int wid, input int hoff, input int d);
      int exp;
      w = CW'(wid); h = CW'(hoff);
      go_idle();
      mark();
      a = 2'b10;
      while (k < 60) begin
         step();
         if (k == d - STB) a = 2'b11;
         if (k == d) a = 2'b10;
      end
      exp = (d > hoff) ? d + wid + 1 : wid + 1;
      if (d > hoff) chk(hi_cnt == exp, "R7 retrigger extends", hi_cnt, exp);
      else          chk(hi_cnt == exp, "R8 retrigger inside holdoff ignored", hi_cnt, exp);
      chk(rises == 1, "R7 no gap", rises, 1);
      go_idle();
   endtask

   initial begin
      rst_n = 1'b0; a = '1; b = '1; c = 1'b1; w = '0; h = '0;
      #1;
      // R11
      chk(q == 1'b0, "R11 reset q", int'(q), 0);
      chk(qn == 1'b1, "R11 reset q_n", int'(qn), 1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mark();
      steps(8);
      chk(hi_cnt == 0, "R11 quiet after reset", hi_cnt, 0);

      // R3 R4 sweep every source against widths 0..5
      for (int s = 0; s < 5; s++)
         for (int wd = 0; wd < 6; wd++) run_src(s, wd);

      // R1 both active-low bits falling together
      w = 4; h = 0; go_idle(); mark(); a = 2'b00; steps(30);
      chk(hi_cnt == 5, "R1 both lo fall", hi_cnt, 5);
      go_idle();

      // R1 all lo inputs high: hi rise does nothing
      b = 2'b10; steps(6); mark(); b = 2'b11; steps(25);
      chk(hi_cnt == 0, "R1 no lo active ignores hi rise", hi_cnt, 0);

      // R2 one hi input low blocks lo fall
      b = 2'b01; steps(6); mark(); a = 2'b10; steps(25);
      chk(hi_cnt == 0, "R2 hi gate blocks", hi_cnt, 0);
      a = 2'b11; steps(6);
      go_idle();

      // R9 one-cycle glitch rejected, STB-cycle level accepted
      w = 3; mark(); a = 2'b10; step(); a = 2'b11; steps(25);
      chk(hi_cnt == 0, "R9 short glitch rejected", hi_cnt, 0);
      mark(); a = 2'b10; steps(STB); a = 2'b11; steps(25);
      chk(hi_cnt == 4, "R9 min-stable level accepted", hi_cnt, 4);
      chk(first_hi == LAT_TRIG, "R9 latency", first_hi, LAT_TRIG);
      go_idle();

      // R6 clear mid-pulse; R5 triggers ignored while clear low
      w = 20; h = 0; mark(); a = 2'b10;
      while (k < 30) begin
         step();
         if (k == 8) c = 1'b0;
      end
      chk(hi_cnt == 8 + LAT_CLR - LAT_TRIG, "R6 clear cuts pulse", hi_cnt, 8 + LAT_CLR - LAT_TRIG);
      mark(); a = 2'b11; steps(6); a = 2'b10; steps(6); a = 2'b11; steps(6); a = 2'b01; steps(20);
      chk(hi_cnt == 0, "R5 triggers ignored under clear", hi_cnt, 0);
      a = 2'b11; steps(6);
      mark(); c = 1'b1; steps(20);
      chk(hi_cnt == 0, "R5 clear rise without lo active", hi_cnt, 0);
      go_idle();

      // R7 R8 retrigger sweep, including D == holdoff and D == holdoff+1
      for (int hi = 0; hi < 4; hi++)
         for (int d = 4; d <= 8; d += 2) run_retrig(10, 2 * hi + 1 + (hi == 3 ? 0 : 0), d);
      run_retrig(10, 6, 6);
      run_retrig(10, 5, 6);
      run_retrig(10, 6, 7);

      // R7 continuous retriggering: 100% duty
      w = 3; h = 1; go_idle(); mark(); a = 2'b10;
      while (k < 70) begin
         step();
         if (k % 4 == 2) a = 2'b11;
         if (k % 4 == 0 && k < 40) a = 2'b10;
      end
      chk(hi_cnt == 40, "R7 continuous high", hi_cnt, 40);
      chk(rises == 1, "R7 no dropout", rises, 1);
      chk(first_hi == LAT_TRIG, "R7 first latency", first_hi, LAT_TRIG);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule